// File: doc/BRIEF.md
# Trap and Return-From-Exception PC Sequencer

This block owns the program counter and the interrupt address register of a simple 32-bit core. It handles only the control transfers tied to the trap and return-from-exception instructions. Each cycle a decode stage presents a valid strobe, three class flags (trap, return, no-op) and the 26-bit immediate field of a jump-format word. The block then produces the next program counter and updates the saved return address. Any instruction that raises none of the flags counts as a normal instruction and advances the PC by one word.

A trap jumps to its 26-bit field, zero-extended to 32 bits, and writes PC+8 into the interrupt address register. A return-from-exception loads the PC from that register. A no-op can never redirect control or touch the saved address. A decode that raises trap and return together, with no no-op, is reported on a flag and treated as a normal instruction. Fetch, hazards and general branches are handled elsewhere.

Top module: `trap_pc_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pc_o` and `iar_o` are 0 until the first valid instruction.
- R2: A valid instruction with all class flags low advances `pc_o` by 4, modulo 2^32, and leaves `iar_o` unchanged.
- R3: A valid trap (trap high, ret and nop low) loads `pc_o` with `vec_field_i` zero-extended to 32 bits: bits 31..26 are 0 and bits 25..0 equal the field.
- R4: A valid trap writes `iar_o` with the pre-trap `pc_o` plus 8, modulo 2^32. A later trap overwrites the earlier value.
- R5: A valid return (ret high, trap and nop low) loads `pc_o` with the current `iar_o` and leaves `iar_o` unchanged.
- R6: When a valid instruction has nop high, the trap and ret flags are ignored: `pc_o` advances by 4, `iar_o` is unchanged and `illegal_o` stays low.
- R7: When a valid instruction has trap and ret both high and nop low, `illegal_o` is 1 in that same cycle, `pc_o` advances by 4 and `iar_o` is unchanged. Otherwise `illegal_o` is 0.
- R8: While `valid_i` is low, `pc_o` and `iar_o` hold their values and `illegal_o` is 0, whatever the other inputs are.
- R9: `next_pc_o` always shows the value that `pc_o` takes at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is present this cycle |
| trap_i | input | 1 | Decoded class: trap |
| ret_i | input | 1 | Decoded class: return from exception |
| nop_i | input | 1 | Decoded class: no-op |
| vec_field_i | input | 26 | Immediate field of the jump-format word |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Program counter for the next cycle |
| iar_o | output | 32 | Interrupt address register |
| illegal_o | output | 1 | Trap and return requested together |

## Verification
The bench sends a trap with an all-ones field. A design that sign-extends the field, or shifts it as a word offset, would put the wrong value in the upper bits. It checks that the saved address is PC+8 and not PC+4, and that a second trap overwrites the saved value, so a return lands on the newer address. It drives nop together with trap and return, which a design with the wrong priority would treat as a redirect. It also drives trap and return together: a flag that is missing, or a PC that jumps in that case, is caught. Finally it holds `valid_i` low while raising the class flags, to show that a stalled cycle changes nothing.

// File: rtl/trap_pc_seq.sv
module trap_pc_seq #(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 26,
  parameter int STEP    = 4,
  parameter int LINK    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic               trap_i,
  input  logic               ret_i,
  input  logic               nop_i,
  input  logic [FIELD_W-1:0] vec_field_i,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    next_pc_o,
  output logic [XLEN-1:0]    iar_o,
  output logic               illegal_o
);
  localparam int PAD = XLEN - FIELD_W;

  logic [XLEN-1:0] pc_q, iar_q, seq_pc, vec_pc;
  logic take_trap, take_ret;

  assign take_trap = valid_i & trap_i & ~ret_i & ~nop_i;
  assign take_ret  = valid_i & ret_i & ~trap_i & ~nop_i;
  assign illegal_o = valid_i & trap_i & ret_i & ~nop_i;

  assign seq_pc = pc_q + XLEN'(STEP);
  assign vec_pc = {{PAD{1'b0}}, vec_field_i};

  always_comb begin
    if (!valid_i)       next_pc_o = pc_q;
    else if (take_trap) next_pc_o = vec_pc;
    else if (take_ret)  next_pc_o = iar_q;
    else                next_pc_o = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      iar_q <= '0;
    end else begin
      pc_q <= next_pc_o;
      if (take_trap) iar_q <= pc_q + XLEN'(LINK);
    end
  end

  assign pc_o  = pc_q;
  assign iar_o = iar_q;

  AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && trap_i && !ret_i && !nop_i) |=> pc_o == {{PAD{1'b0}}, $past(vec_field_i)}); // R3
  AST_TRAP_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && trap_i && !ret_i && !nop_i) |=> iar_o == $past(pc_o) + XLEN'(LINK)); // R4
  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && ret_i && !trap_i && !nop_i) |=> pc_o == $past(iar_o)); // R5
  AST_NOP_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && nop_i) |=> (pc_o == $past(pc_o) + XLEN'(STEP)) && $stable(iar_o)); // R6
  AST_ILLEGAL_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> (pc_o == $past(pc_o) + XLEN'(STEP)) && $stable(iar_o)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pc_o) && $stable(iar_o)); // R8
  AST_STALL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !illegal_o); // R8
endmodule

// File: tb/test_trap_pc_seq.sv
module test_trap_pc_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i, trap_i, ret_i, nop_i;
  logic [25:0] vec_field_i;
  logic [31:0] pc_o, next_pc_o, iar_o;
  logic        illegal_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_pc, exp_iar;

  always #2.5 clk = ~clk;

  trap_pc_seq i_trap_pc_seq (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .trap_i(trap_i),
    .ret_i(ret_i), .nop_i(nop_i), .vec_field_i(vec_field_i),
    .pc_o(pc_o), .next_pc_o(next_pc_o), .iar_o(iar_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one instruction: drive at negedge, check comb outputs, then registers after edge
  task automatic step(input string req, input logic v, input logic t, input logic r,
                      input logic n, input logic [25:0] f);
    logic [31:0] nxt, niar;
    logic        ill;
    @(negedge clk);
    valid_i = v; trap_i = t; ret_i = r; nop_i = n; vec_field_i = f;
    ill  = v & t & r & ~n;
    nxt  = exp_pc;
    niar = exp_iar;
    if (v) begin
      if (t && !r && !n)      begin nxt = {6'b0, f}; niar = exp_pc + 32'd8; end
      else if (r && !t && !n) nxt = exp_iar;
      else                    nxt = exp_pc + 32'd4;
    end
    #1;
    chk({req, " illegal_o"}, {31'b0, illegal_o}, {31'b0, ill});
    chk("R9 next_pc_o", next_pc_o, nxt);
    @(posedge clk); #1;
    exp_pc = nxt; exp_iar = niar;
    chk({req, " pc_o"}, pc_o, exp_pc);
    chk({req, " iar_o"}, iar_o, exp_iar);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; valid_i = 1'b1; trap_i = 1'b1; ret_i = 1'b0; nop_i = 1'b0;
    vec_field_i = 26'h155;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pc_o in reset", pc_o, 32'h0);
    chk("R1 iar_o in reset", iar_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1; valid_i = 1'b0;
    #1;
    exp_pc = 32'h0; exp_iar = 32'h0;
    chk("R1 pc_o after reset", pc_o, 32'h0);
  endtask

  task automatic t_normal;
    for (int i = 0; i < 3; i++) step("R2 normal", 1, 0, 0, 0, 26'h3ab);
  endtask

  task automatic t_trap_ret;
    step("R3 trap small field", 1, 1, 0, 0, 26'h0123);
    chk("R4 link is pc+8", iar_o, 32'h14);
    step("R2 in handler", 1, 0, 0, 0, 26'h0);
    step("R5 return", 1, 0, 1, 0, 26'h2aa);
    chk("R5 landed on link", pc_o, 32'h14);
  endtask

  task automatic t_wide_field;
    step("R3 trap all-ones field", 1, 1, 0, 0, 26'h3ffffff);
    chk("R3 upper bits zero", pc_o, 32'h03ffffff);
    step("R4 second trap overwrites", 1, 1, 0, 0, 26'h0040);
    chk("R4 link from wide pc", iar_o, 32'h04000007);
    step("R5 return to newest link", 1, 0, 1, 0, 26'h0);
  endtask

  task automatic t_nop;
    step("R6 nop alone", 1, 0, 0, 1, 26'h10);
    step("R6 nop with trap", 1, 1, 0, 1, 26'h10);
    step("R6 nop with ret", 1, 0, 1, 1, 26'h10);
    step("R6 nop with both", 1, 1, 1, 1, 26'h10);
  endtask

  task automatic t_illegal;
    step("R7 trap and ret together", 1, 1, 1, 0, 26'h200);
    step("R7 after illegal", 1, 0, 0, 0, 26'h0);
  endtask

  task automatic t_stall;
    step("R8 stall with trap", 0, 1, 0, 0, 26'h3ff);
    step("R8 stall with ret", 0, 0, 1, 0, 26'h0);
    step("R8 stall with both", 0, 1, 1, 0, 26'h0);
    step("R2 resume", 1, 0, 0, 0, 26'h0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_normal();
        t_trap_ret();
        t_wide_field();
        t_nop();
        t_illegal();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule